// File: doc/BRIEF.md
# Programmable Pulse Train Generator

This block drives a single digital line with a train of pulses. Each pulse has a high phase and a low phase, and each phase lasts a set number of timebase ticks. The timebase arrives as a one-cycle enable strobe, so the caller decides how fast the ticks come. The block counts only the cycles in which that strobe is high.

A start request captures the two tick counts and a signed pulse count. A positive count gives a finite train, and the block signals the end of that train with a one-cycle done pulse. A count of all ones (-1 in two's complement) gives an endless train. An endless train runs until a stop request, and it accepts new tick counts while it runs. Those new counts are applied only at a period boundary, so no phase is ever cut short or stretched.

A stop request always lets the current period finish, so the line always returns low cleanly.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset and whenever `busy_o` is low, `pulse_o` and `done_o` are low.
- R2: The cycle after an accepted start, `busy_o` and `pulse_o` go high. The high phase lasts exactly `hi_ticks` cycles in which `tick_en` is high, and the low phase lasts exactly `lo_ticks` such cycles. Cycles in which `tick_en` is low do not advance either phase.
- R3: A start with `pulse_cnt` between 1 and 2^(CNT_W-1)-1 produces exactly that many pulses. The cycle after the tick that ends the final low phase, `done_o` is high and `busy_o` is low.
- R4: A start with `pulse_cnt` equal to all ones (-1) produces pulses without end until a stop request.
- R5: A tick value of zero, for either phase, is treated as one tick.
- R6: `stop` while busy lets the current period run through the end of its low phase. The train then ends as in R3, with `done_o` for one cycle and the line low. `stop` while idle has no effect.
- R7: While an endless train runs, `upd` captures `hi_ticks` and `lo_ticks`. The captured values take effect from the next high phase that starts in or after that cycle. If several updates arrive before that boundary, the last one wins. `upd` during a finite train or while idle has no effect.
- R8: `start` while busy is ignored. `start` with `pulse_cnt` equal to zero, or negative other than -1, leaves the block idle.
- R9: `done_o` is never high in two consecutive cycles. It is high only in the cycle in which `busy_o` has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timebase enable strobe, one cycle per tick |
| hi_ticks | input | TICK_W | High-phase length in ticks (0 is taken as 1) |
| lo_ticks | input | TICK_W | Low-phase length in ticks (0 is taken as 1) |
| pulse_cnt | input | CNT_W | Two's-complement pulse count; all ones selects an endless train |
| start | input | 1 | Begin a train when idle |
| stop | input | 1 | End the train at the end of the current period |
| upd | input | 1 | Capture new tick values during an endless train |
| pulse_o | output | 1 | Pulse line |
| busy_o | output | 1 | High while a train is running |
| done_o | output | 1 | One-cycle end-of-train indication |

## Verification
On every cycle, the checker confirms four things: the line is low while idle, done lasts one cycle and coincides with busy falling, a new train opens with a high phase, and the line holds still across cycles without a tick. Only the bench's scenarios can show the phase lengths and the exact pulse counts. The same holds for deferring updated timing to a period boundary, letting a stopped period run to its end, and discarding start, stop and update requests that must have no effect. The bench covers these with gapped and continuous tick patterns against a behavioural model.

// File: rtl/pt_pkg.sv
package pt_pkg;
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;
endpackage

// File: rtl/pt_tick_timer.sv
// Counts ticks within the current phase and flags the tick that closes it.
module pt_tick_timer #(
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              restart,
   input  logic [TICK_W-1:0] len,
   output logic              phase_end
);
   logic [TICK_W-1:0] cnt_q;

   assign phase_end = run & tick & (cnt_q == len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (restart || phase_end) cnt_q <= '0;
      else if (run && tick)        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pt_seq.sv
// Train sequencing: mode, remaining pulses, phase, stop deferral, done.
module pt_seq
   import pt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic             phase_end,
   output logic             busy,
   output phase_e           phase,
   output logic             start_ok,
   output logic             finish,
   output logic             endless,
   output logic             done
);
   localparam logic [CNT_W-1:0] CNT_FOREVER = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

   logic [CNT_W-1:0] rem_q;
   logic             stop_q;
   logic             cnt_valid;
   logic             stop_eff;

   assign cnt_valid = (cnt_in == CNT_FOREVER) ||
                      (!cnt_in[CNT_W-1] && (cnt_in != '0));
   assign start_ok  = start & ~busy & cnt_valid;
   assign stop_eff  = stop | stop_q;
   assign finish    = busy & phase_end & (phase == PH_LOW) &
                      (stop_eff | (~endless & (rem_q == CNT_ONE)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         phase   <= PH_LOW;
         rem_q   <= '0;
         endless <= 1'b0;
         stop_q  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= finish;
         if (start_ok) begin
            busy    <= 1'b1;
            phase   <= PH_HIGH;
            rem_q   <= cnt_in;
            endless <= (cnt_in == CNT_FOREVER);
            stop_q  <= 1'b0;
         end else if (busy) begin
            if (finish) begin
               busy   <= 1'b0;
               phase  <= PH_LOW;
               stop_q <= 1'b0;
            end else begin
               if (stop) stop_q <= 1'b1;
               if (phase_end) begin
                  if (phase == PH_HIGH) begin
                     phase <= PH_LOW;
                  end else begin
                     phase <= PH_HIGH;
                     if (!endless) rem_q <= rem_q - 1'b1;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/pt_timing.sv
// Active and pending phase lengths; pending values move in at period start.
module pt_timing
   import pt_pkg::*;
#(
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              upd_ok,
   input  logic              restart,
   input  logic [TICK_W-1:0] hi_in,
   input  logic [TICK_W-1:0] lo_in,
   input  phase_e            phase,
   output logic [TICK_W-1:0] len
);
   localparam logic [TICK_W-1:0] MIN_LEN = TICK_W'(1);

   logic [TICK_W-1:0] hi_cl, lo_cl;
   logic [TICK_W-1:0] act_hi_q, act_lo_q, pnd_hi_q, pnd_lo_q;
   logic              pnd_v_q;

   assign hi_cl = (hi_in == '0) ? MIN_LEN : hi_in;
   assign lo_cl = (lo_in == '0) ? MIN_LEN : lo_in;
   assign len   = (phase == PH_HIGH) ? act_hi_q : act_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_hi_q <= MIN_LEN;
         act_lo_q <= MIN_LEN;
         pnd_hi_q <= MIN_LEN;
         pnd_lo_q <= MIN_LEN;
         pnd_v_q  <= 1'b0;
      end else if (load) begin
         act_hi_q <= hi_cl;
         act_lo_q <= lo_cl;
         pnd_v_q  <= 1'b0;
      end else if (restart) begin
         if (upd_ok) begin
            act_hi_q <= hi_cl;
            act_lo_q <= lo_cl;
         end else if (pnd_v_q) begin
            act_hi_q <= pnd_hi_q;
            act_lo_q <= pnd_lo_q;
         end
         pnd_v_q <= 1'b0;
      end else if (upd_ok) begin
         pnd_hi_q <= hi_cl;
         pnd_lo_q <= lo_cl;
         pnd_v_q  <= 1'b1;
      end
   end
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
   import pt_pkg::*;
#(
   parameter int TICK_W  = 16,
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [TICK_W-1:0] hi_ticks,
   input  logic [TICK_W-1:0] lo_ticks,
   input  logic [CNT_W-1:0]  pulse_cnt,
   input  logic              start,
   input  logic              stop,
   input  logic              upd,
   output logic              pulse_o,
   output logic              busy_o,
   output logic              done_o
);
   if (TICK_W < 2) begin : g_bad_tick_w
      $error("pulse_train_gen: TICK_W must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("pulse_train_gen: CNT_W must be at least 2");
   end

   logic              busy, start_ok, finish, endless, done, phase_end;
   logic              restart, upd_ok, line;
   phase_e            phase;
   logic [TICK_W-1:0] len;

   assign restart = phase_end & (phase == PH_LOW) & ~finish;
   assign upd_ok  = upd & busy & endless;
   assign line    = busy & (phase == PH_HIGH);

   pt_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .cnt_in(pulse_cnt), .phase_end(phase_end), .busy(busy),
      .phase(phase), .start_ok(start_ok), .finish(finish),
      .endless(endless), .done(done)
   );

   pt_timing #(.TICK_W(TICK_W)) u_timing (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .upd_ok(upd_ok),
      .restart(restart), .hi_in(hi_ticks), .lo_in(lo_ticks),
      .phase(phase), .len(len)
   );

   pt_tick_timer #(.TICK_W(TICK_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick_en),
      .restart(start_ok), .len(len), .phase_end(phase_end)
   );

   if (OUT_REG) begin : g_out_reg
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q <= 1'b0;
         else        line_q <= line;
      end
      assign pulse_o = line_q;
   end else begin : g_out_comb
      assign pulse_o = line;
   end

   assign busy_o = busy;
   assign done_o = done;
endmodule

// File: rtl/pulse_train_gen_chk.sv
module pulse_train_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic pulse_o,
   input logic busy_o,
   input logic done_o
);
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !pulse_o) else $error("idle line high"); // R1
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done too long"); // R9
   AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))) else $error("done without end"); // R3
   AST_END_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o) else $error("end without done"); // R6
   AST_OPEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> pulse_o) else $error("train opened low"); // R2
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && busy_o && !$past(tick_en)) |-> $stable(pulse_o))
      else $error("line moved without tick"); // R2
endmodule

bind pulse_train_gen pulse_train_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
   .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/pulse_train_gen_tb.sv
module pulse_train_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic [TW-1:0] hi_ticks = '0, lo_ticks = '0;
   logic [CW-1:0] pulse_cnt = '0;
   logic start = 1'b0, stop = 1'b0, upd = 1'b0;
   logic pulse_o, busy_o, done_o;

   int n_vec = 0, n_fail = 0, cyc = 0, tick_mode = 0, rises = 0;
   string req = "R1";
   logic prev_pulse = 1'b0;

   // behavioural reference
   int  m_busy = 0, m_high = 0, m_el = 0, m_left = 0, m_endless = 0;
   int  m_stopreq = 0, m_hi = 1, m_lo = 1, m_done = 0;
   int  q_hi[$], q_lo[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_train_gen #(.TICK_W(TW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hi_ticks(hi_ticks),
      .lo_ticks(lo_ticks), .pulse_cnt(pulse_cnt), .start(start), .stop(stop),
      .upd(upd), .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o)
   );

   function automatic int at_least_one(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(posedge clk) begin
      int c;
      int sreq;
      c = int'($signed(pulse_cnt));
      m_done = 0;
      if (!rst_n) begin
         m_busy = 0; m_high = 0; m_el = 0; m_stopreq = 0;
         q_hi.delete(); q_lo.delete();
      end else if (m_busy == 0) begin
         if (start && (c == -1 || c > 0)) begin
            m_busy = 1; m_high = 1; m_el = 0; m_left = c;
            m_endless = (c == -1); m_stopreq = 0;
            m_hi = at_least_one(int'(hi_ticks));
            m_lo = at_least_one(int'(lo_ticks));
            q_hi.delete(); q_lo.delete();
         end
      end else begin
         sreq = (stop || m_stopreq) ? 1 : 0;
         if (upd && m_endless != 0) begin
            q_hi.push_back(at_least_one(int'(hi_ticks)));
            q_lo.push_back(at_least_one(int'(lo_ticks)));
         end
         if (tick_en) begin
            m_el++;
            if (m_high != 0 && m_el == m_hi) begin
               m_high = 0; m_el = 0;
            end else if (m_high == 0 && m_el == m_lo) begin
               if (sreq != 0 || (m_endless == 0 && m_left == 1)) begin
                  m_busy = 0; m_done = 1; m_el = 0; m_stopreq = 0;
               end else begin
                  m_left--; m_high = 1; m_el = 0;
                  if (q_hi.size() > 0) begin
                     m_hi = q_hi[$]; m_lo = q_lo[$];
                     q_hi.delete(); q_lo.delete();
                  end
               end
            end
         end
         if (stop && m_busy != 0) m_stopreq = 1;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (tick_mode == 0) tick_en <= 1'b1;
      else                tick_en <= (cyc % 3 == 0);
      if (rst_n) begin
         n_vec++;
         if (pulse_o !== (m_busy != 0 && m_high != 0) ||
             busy_o !== (m_busy != 0) || done_o !== (m_done != 0)) begin
            n_fail++;
            $display("FAIL %s cyc %0d: pulse/busy/done act=%b%b%b exp=%b%b%b",
                     req, cyc, pulse_o, busy_o, done_o,
                     (m_busy != 0 && m_high != 0), (m_busy != 0), (m_done != 0));
         end
         if (pulse_o && !prev_pulse) rises++;
         prev_pulse = pulse_o;
      end
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   task automatic check(input string r, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", r, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic begin_train(input int h, input int l, input int c);
      @(negedge clk);
      hi_ticks = TW'(h); lo_ticks = TW'(l); pulse_cnt = CW'(c);
      rises = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle(input int limit);
      int k;
      k = 0;
      while (busy_o && k < limit) begin
         @(negedge clk);
         k++;
      end
   endtask

   initial begin
      // R1: reset state
      cycles(3);
      check("R1 reset pulse", int'(pulse_o), 0);
      check("R1 reset busy", int'(busy_o), 0);
      rst_n = 1'b1;
      cycles(2);
      check("R1 idle done", int'(done_o), 0);

      // R2 R3: finite, continuous ticks
      req = "R3";
      begin_train(2, 3, 3);
      wait_idle(200);
      cycles(2);
      check("R3 pulse count", rises, 3);

      // R2: gapped ticks
      req = "R2";
      tick_mode = 1;
      begin_train(4, 1, 2);
      wait_idle(400);
      cycles(2);
      check("R2 pulse count gapped", rises, 2);
      tick_mode = 0;

      // R5: zero ticks
      req = "R5";
      begin_train(0, 0, 4);
      wait_idle(200);
      cycles(2);
      check("R5 pulse count", rises, 4);

      // R8: invalid counts leave block idle
      req = "R8";
      begin_train(3, 3, 0);
      check("R8 zero count busy", int'(busy_o), 0);
      begin_train(3, 3, -5);
      check("R8 negative count busy", int'(busy_o), 0);

      // R8: start while busy ignored
      begin_train(3, 2, 2);
      hi_ticks = 9; lo_ticks = 9; pulse_cnt = 7; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_idle(200);
      cycles(2);
      check("R8 restart ignored count", rises, 2);

      // R7: update ignored in finite mode
      req = "R7";
      begin_train(2, 2, 3);
      cycles(1);
      hi_ticks = 7; lo_ticks = 7; upd = 1'b1;
      @(negedge clk); upd = 1'b0;
      wait_idle(200);
      cycles(2);
      check("R7 finite update ignored count", rises, 3);

      // R6: stop while idle ignored
      req = "R6";
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      cycles(2);
      check("R6 idle stop busy", int'(busy_o), 0);

      // R4 R7: endless train with on-the-fly changes
      req = "R4";
      begin_train(3, 2, -1);
      cycles(40);
      check("R4 still busy", int'(busy_o), 1);
      req = "R7";
      cycles(1);
      hi_ticks = 1; lo_ticks = 5; upd = 1'b1;
      @(negedge clk);
      hi_ticks = 2; lo_ticks = 4;
      @(negedge clk); upd = 1'b0;
      cycles(30);
      tick_mode = 1;
      hi_ticks = 0; lo_ticks = 3; upd = 1'b1;
      @(negedge clk); upd = 1'b0;
      cycles(40);
      // R6: stop ends at the period end
      req = "R6";
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      wait_idle(400);
      cycles(2);
      check("R6 stopped busy", int'(busy_o), 0);
      check("R6 stopped line", int'(pulse_o), 0);
      tick_mode = 0;

      // R9: short finite train, done single cycle (checked each cycle)
      req = "R9";
      begin_train(1, 1, 1);
      wait_idle(50);
      cycles(3);
      check("R9 one pulse", rises, 1);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule